// File: doc/BRIEF.md
# Four-Channel Serial Management Slave

This block is the management-interface slave of a PHY with four ports. A station drives a slow serial clock (MDC) and a shared data line (MDIO). The slave oversamples both with the chip clock, acts on each rising edge of MDC, and decodes a framed transaction: preamble, start pattern, opcode, a five-bit device address, a five-bit register address, two turnaround slots and a 16-bit data field. The upper three device-address bits must match strap inputs. The lower two bits pick one of four channels. Each channel holds eleven 16-bit registers at addresses 0 to 5 and 16 to 20.

The data line appears as three plain signals: an input, an output and an output enable. An external pad or tri-state buffer merges them. With bulk mode enabled, a read of register address 31 streams every register of every channel in one long data phase of 704 bits. The core sees the register contents through a plain combinational read port. The block has no data stream that would need back-pressure. Every pin is a level or a strobe without a handshake.

Top module: `mdio_quad_slave`

## Requirements
- R1: After reset, `mdio_oe` is 0. On every channel c, register 0 holds 0x3100, register 1 holds 0x7849, register 2 holds 0x0016, register 3 holds 0xF840 + c, and registers 4, 5 and 16 to 20 hold 0x0000.
- R2: A start pattern is accepted only after at least 32 consecutive 1 bits sampled on MDC rising edges. A 0 that arrives earlier clears the count, and the frame that follows is ignored.
- R3: The two bits after the preamble must be 0 then 1. Any other pair aborts the frame, and the slave hunts for a fresh preamble of 32 ones.
- R4: Device-address bits [4:2] (first sent is bit 4) must equal `phy_strap`, or the frame neither drives MDIO nor writes. Bits [1:0] select the channel.
- R5: With opcode 10 (read), the slave leaves MDIO undriven in the first turnaround slot and drives 0 in the second. It then drives the 16 register bits MSB first and releases the line in the slot after the last bit. Each new output value appears only after an MDC rising edge.
- R6: With opcode 01 (write), the slave ignores both turnaround slots, samples the 16 data bits MSB first on MDC rising edges, and stores them into the addressed register of the selected channel.
- R7: With opcode 00 or 11, the slave never drives MDIO and changes no register.
- R8: A read of an unimplemented address (6 to 15, 21 to 31, or 31 when bulk mode is off) returns 0x0000. A write to such an address is discarded.
- R9: With `bulk_en` high, a read of address 31 streams 704 bits after the turnaround: channels 0 to 3 in turn, and within each channel registers 0, 1, 2, 3, 4, 5, 16, 17, 18, 19, 20, each MSB first. The device-address low bits play no part in this.
- R10: A write to address 31 changes no register, whether bulk mode is on or off.
- R11: `core_rdata` shows, combinationally, the register selected by `core_ch` and `core_addr`. It shows 0x0000 for an unimplemented address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample MDC and MDIO |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| mdc | input | 1 | Management serial clock from the station |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value the slave drives |
| mdio_oe | output | 1 | High while the slave drives the data line |
| phy_strap | input | 3 | Expected upper device-address bits |
| bulk_en | input | 1 | Enables the all-register read at address 31 |
| core_ch | input | 2 | Channel for the core read port |
| core_addr | input | 5 | Register address for the core read port |
| core_rdata | output | 16 | Register value for the core read port |

## Verification
The assertions assume that MDC is much slower than `clk`, so that each MDC level lasts longer than the synchronizer depth plus one cycle and every rising edge gives exactly one strobe. They also assume that `mdio_i` is settled well before each MDC rise. The bench runs MDC at one eighth of the chip clock and changes `mdio_i` only at the start of the MDC low phase, so both conditions hold by a wide margin. The bench changes `bulk_en` only between frames, so the bulk decision never sees it change in the middle of a header.

// File: rtl/mdio_quad_pkg.sv
package mdio_quad_pkg;

  // fixed register map per channel
  localparam int REGS_PER_CH = 11;
  localparam int ADDR_W      = 5;
  localparam int HDR_BITS    = 12;   // opcode + device address + register address

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    FR_HUNT,
    FR_START,
    FR_HDR,
    FR_READ,
    FR_WRITE
  } fr_state_t;

  // dense slot index -> register address (0..5 stay, 6..10 map to 16..20)
  function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
    if (idx < 6) return ADDR_W'(idx);
    return ADDR_W'(idx + 10);
  endfunction

  function automatic logic addr_impl(input logic [ADDR_W-1:0] a);
    return (a <= 5'd5) || ((a >= 5'd16) && (a <= 5'd20));
  endfunction

  function automatic logic [15:0] init_word(input int ch, input int idx);
    case (idx)
      0:       return 16'h3100;
      1:       return 16'h7849;
      2:       return 16'h0016;
      3:       return 16'hF840 | 16'(ch);
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic bit_val
);

  logic [STAGES-1:0] mdc_sh;
  logic [STAGES-1:0] dat_sh;
  logic              mdc_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_sh   <= '1;
      dat_sh   <= '1;
      mdc_last <= 1'b1;
    end else begin
      mdc_sh[0] <= mdc;
      dat_sh[0] <= mdio_i;
      for (int k = 1; k < STAGES; k++) begin
        mdc_sh[k] <= mdc_sh[k-1];
        dat_sh[k] <= dat_sh[k-1];
      end
      mdc_last <= mdc_sh[STAGES-1];
    end
  end

  assign mdc_rise = mdc_sh[STAGES-1] & ~mdc_last;
  assign bit_val  = dat_sh[STAGES-1];

  // R5: one strobe per MDC rising edge
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_rise |=> !mdc_rise);

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_quad_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [CHW-1:0]    rd_ch,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [CHW-1:0]    cr_ch,
  input  logic [ADDR_W-1:0] cr_addr,
  output logic [DW-1:0]     cr_data
);

  localparam int WORDS = NCH * REGS_PER_CH;

  logic [DW-1:0] flat [WORDS];

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    for (genvar gi = 0; gi < REGS_PER_CH; gi++) begin : g_reg
      logic [DW-1:0] word_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          word_q <= DW'(init_word(gc, gi));
        else if (wr_en && (wr_ch == CHW'(gc)) && (wr_addr == slot_addr(gi)))
          word_q <= wr_data;
      end
      assign flat[gc*REGS_PER_CH + gi] = word_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < REGS_PER_CH; i++)
        if ((rd_ch == CHW'(c)) && (rd_addr == slot_addr(i)))
          rd_data = flat[c*REGS_PER_CH + i];
  end

  always_comb begin
    cr_data = '0;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < REGS_PER_CH; i++)
        if ((cr_ch == CHW'(c)) && (cr_addr == slot_addr(i)))
          cr_data = flat[c*REGS_PER_CH + i];
  end

  // R8: write strobes only reach implemented addresses
  a_r8_write_implemented: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> addr_impl(wr_addr));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_quad_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int PRE_MIN = 32,
  parameter int CHW     = $clog2(NCH),
  parameter int STRAP_W = ADDR_W - CHW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic [STRAP_W-1:0] strap,
  input  logic               bulk_en,
  output logic [CHW-1:0]     rd_ch,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [DW-1:0]      rd_data,
  output logic               wr_en,
  output logic [CHW-1:0]     wr_ch,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic               mdio_o,
  output logic               mdio_oe
);

  localparam int PCW   = $clog2(PRE_MIN + 1);
  localparam int WORDS = NCH * REGS_PER_CH;
  localparam int WCW   = $clog2(WORDS + 1);
  localparam int BW    = $clog2(DW);
  localparam int IXW   = $clog2(REGS_PER_CH);
  localparam int CW    = $clog2(DW + HDR_BITS + 2);

  fr_state_t            state;
  logic [PCW-1:0]       pre_cnt;
  logic [CW-1:0]        cnt;
  logic [HDR_BITS-2:0]  hdr;
  logic [CHW-1:0]       ch_q;
  logic [ADDR_W-1:0]    addr_q;
  logic                 bulk_q;
  logic [IXW-1:0]       bidx;
  logic [WCW-1:0]       words_left;
  logic [BW-1:0]        bitc;
  logic [DW-1:0]        sh;
  logic [DW-2:0]        wsh;
  logic                 streaming;
  logic                 done;
  logic                 drv_o;
  logic                 drv_oe;

  // header decode on the last header bit
  logic [HDR_BITS-1:0]  hdr_full;
  logic [1:0]           op;
  logic [ADDR_W-1:0]    pa;
  logic [ADDR_W-1:0]    ra;
  logic                 pa_match;
  logic                 op_known;
  logic                 bulk_hit;

  assign hdr_full = {hdr, bit_val};
  assign op       = hdr_full[HDR_BITS-1 -: 2];
  assign pa       = hdr_full[2*ADDR_W-1 -: ADDR_W];
  assign ra       = hdr_full[ADDR_W-1:0];
  assign pa_match = (pa[ADDR_W-1:CHW] == strap);
  assign op_known = (op == OP_RD) || (op == OP_WR);
  assign bulk_hit = bulk_en && (ra == '1);

  // bulk pointer advance: next slot within channel, then next channel
  logic               last_in_ch;
  logic [IXW-1:0]     nxt_bidx;
  logic [CHW-1:0]     nxt_ch;

  assign last_in_ch = (bidx == IXW'(REGS_PER_CH - 1));
  assign nxt_bidx   = last_in_ch ? '0 : bidx + 1'b1;
  assign nxt_ch     = last_in_ch ? ch_q + 1'b1 : ch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= FR_HUNT;
      pre_cnt    <= '0;
      cnt        <= '0;
      hdr        <= '0;
      ch_q       <= '0;
      addr_q     <= '0;
      bulk_q     <= 1'b0;
      bidx       <= '0;
      words_left <= '0;
      bitc       <= '0;
      sh         <= '0;
      wsh        <= '0;
      streaming  <= 1'b0;
      done       <= 1'b0;
      drv_o      <= 1'b0;
      drv_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bit_stb) begin
        unique case (state)
          FR_HUNT: begin
            if (bit_val) begin
              if (pre_cnt != PCW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
            end else if (pre_cnt == PCW'(PRE_MIN)) begin
              state <= FR_START;
            end else begin
              pre_cnt <= '0;
            end
          end

          FR_START: begin
            pre_cnt <= '0;
            if (bit_val) begin
              state <= FR_HDR;
              cnt   <= '0;
            end else begin
              state <= FR_HUNT;
            end
          end

          FR_HDR: begin
            hdr <= hdr_full[HDR_BITS-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HDR_BITS - 1)) begin
              if (!pa_match || !op_known) begin
                state   <= FR_HUNT;
                pre_cnt <= '0;
              end else if (op == OP_RD) begin
                state     <= FR_READ;
                streaming <= 1'b0;
                done      <= 1'b0;
                bulk_q    <= bulk_hit;
                if (bulk_hit) begin
                  ch_q       <= '0;
                  bidx       <= '0;
                  addr_q     <= slot_addr(0);
                  words_left <= WCW'(WORDS - 1);
                end else begin
                  ch_q       <= pa[CHW-1:0];
                  addr_q     <= ra;
                  words_left <= '0;
                end
              end else begin
                state  <= FR_WRITE;
                cnt    <= '0;
                ch_q   <= pa[CHW-1:0];
                addr_q <= ra;
              end
            end
          end

          FR_READ: begin
            if (!streaming) begin
              // end of first turnaround slot: drive 0, fetch first word
              drv_oe    <= 1'b1;
              drv_o     <= 1'b0;
              sh        <= rd_data;
              bitc      <= '0;
              streaming <= 1'b1;
              if (bulk_q) begin
                ch_q   <= nxt_ch;
                bidx   <= nxt_bidx;
                addr_q <= slot_addr(int'(nxt_bidx));
              end
            end else if (done) begin
              drv_oe  <= 1'b0;
              drv_o   <= 1'b0;
              state   <= FR_HUNT;
              pre_cnt <= '0;
            end else begin
              drv_o <= sh[DW-1];
              if (bitc == BW'(DW - 1)) begin
                bitc <= '0;
                if (words_left == '0) begin
                  done <= 1'b1;
                end else begin
                  sh         <= rd_data;
                  words_left <= words_left - 1'b1;
                  ch_q       <= nxt_ch;
                  bidx       <= nxt_bidx;
                  addr_q     <= slot_addr(int'(nxt_bidx));
                end
              end else begin
                sh   <= {sh[DW-2:0], 1'b0};
                bitc <= bitc + 1'b1;
              end
            end
          end

          FR_WRITE: begin
            cnt <= cnt + 1'b1;
            if (cnt >= CW'(2)) wsh <= {wsh[DW-3:0], bit_val};
            if (cnt == CW'(DW + 1)) begin
              wr_en   <= addr_impl(addr_q);
              wr_data <= {wsh, bit_val};
              state   <= FR_HUNT;
              pre_cnt <= '0;
            end
          end

          default: state <= FR_HUNT;
        endcase
      end
    end
  end

  assign rd_ch   = ch_q;
  assign rd_addr = addr_q;
  assign wr_ch   = ch_q;
  assign wr_addr = addr_q;
  assign mdio_o  = drv_o;
  assign mdio_oe = drv_oe;

  // R2: start accepted only with a full preamble count
  a_r2_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_START && $past(state) == FR_HUNT) |-> ($past(pre_cnt) == PCW'(PRE_MIN)));

  // R4: never driving while hunting
  a_r4_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_HUNT) |-> !mdio_oe);

  // R5: the first driven slot is the low turnaround bit
  a_r5_ta_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R5: line changes only right after an MDC rising edge
  a_r5_change_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdio_oe != $past(mdio_oe)) || (mdio_o != $past(mdio_o))) |-> $past(bit_stb));

  // R6: register writes come only from a write frame
  a_r6_write_source: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(state) == FR_WRITE));

  // R9: bulk streaming needs the enable at decode time
  a_r9_bulk_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_READ && $past(state) == FR_HDR && bulk_q) |-> $past(bulk_en));

endmodule

// File: rtl/mdio_quad_slave.sv
module mdio_quad_slave
  import mdio_quad_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 16,
  parameter int PRE_MIN     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = $clog2(NCH),
  localparam int STRAP_W    = ADDR_W - CHW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mdc,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic [STRAP_W-1:0] phy_strap,
  input  logic               bulk_en,
  input  logic [CHW-1:0]     core_ch,
  input  logic [ADDR_W-1:0]  core_addr,
  output logic [DW-1:0]      core_rdata
);

  logic              bit_stb;
  logic              bit_val;
  logic [CHW-1:0]    rd_ch;
  logic [ADDR_W-1:0] rd_addr;
  logic [DW-1:0]     rd_data;
  logic              wr_en;
  logic [CHW-1:0]    wr_ch;
  logic [ADDR_W-1:0] wr_addr;
  logic [DW-1:0]     wr_data;

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdc_rise (bit_stb),
    .bit_val  (bit_val)
  );

  mdio_frame_fsm #(.NCH(NCH), .DW(DW), .PRE_MIN(PRE_MIN)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .strap   (phy_strap),
    .bulk_en (bulk_en),
    .rd_ch   (rd_ch),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_reg_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_ch   (rd_ch),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cr_ch   (core_ch),
    .cr_addr (core_addr),
    .cr_data (core_rdata)
  );

endmodule

// File: tb/sim_mdio_quad_slave.sv
`timescale 1ns/1ps
module sim_mdio_quad_slave;

  localparam logic [2:0] STRAP = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;
  logic        bulk_en = 1'b0;
  logic [1:0]  core_ch = '0;
  logic [4:0]  core_addr = '0;
  logic [15:0] core_rdata;

  int total = 0;
  int bad = 0;
  logic [15:0] model [4][32];

  always #4 clk = ~clk;   // 125 MHz

  mdio_quad_slave u0 (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .phy_strap(STRAP),
    .bulk_en(bulk_en), .core_ch(core_ch), .core_addr(core_addr),
    .core_rdata(core_rdata)
  );

  function automatic bit impl(input int a);
    return (a <= 5) || (a >= 16 && a <= 20);
  endfunction

  function automatic int order_addr(input int i);
    return (i < 6) ? i : i + 10;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // one MDC period: drive during low phase, check slave drive before the rise
  task automatic slot(input logic b, input logic eoe, input logic eo, input string rq);
    @(negedge clk);
    mdc = 1'b0;
    mdio_i = b;
    repeat (3) @(negedge clk);
    chk(rq, 32'(mdio_oe), 32'(eoe), "mdio_oe");
    if (eoe) chk(rq, 32'(mdio_o), 32'(eo), "mdio_o bit");
    mdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pre(input int n, input string rq);
    repeat (n) slot(1'b1, 1'b0, 1'b0, rq);
  endtask

  task automatic expect_word(input logic [15:0] w, input string rq);
    for (int k = 15; k >= 0; k--) slot(1'b1, 1'b1, w[k], rq);
  endtask

  task automatic frame(input bit live_in, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, input string rq);
    logic [13:0] hb;
    bit live, rd, wr, bk;
    hb   = {2'b01, op, pa, ra};
    live = live_in && (pa[4:2] == STRAP);
    rd   = live && (op == 2'b10);
    wr   = live && (op == 2'b01);
    bk   = rd && bulk_en && (ra == 5'd31);
    for (int i = 13; i >= 0; i--) slot(hb[i], 1'b0, 1'b0, rq);
    if (rd) begin
      slot(1'b1, 1'b0, 1'b0, rq);
      slot(1'b1, 1'b1, 1'b0, rq);
      if (bk) begin
        for (int c = 0; c < 4; c++)
          for (int i = 0; i < 11; i++)
            expect_word(model[c][order_addr(i)], rq);
      end else begin
        expect_word(impl(int'(ra)) ? model[pa[1:0]][ra] : 16'h0000, rq);
      end
    end else begin
      slot(1'b1, 1'b0, 1'b0, rq);
      slot(1'b0, 1'b0, 1'b0, rq);
      for (int k = 15; k >= 0; k--) slot(wd[k], 1'b0, 1'b0, rq);
      if (wr && impl(int'(ra))) model[pa[1:0]][ra] = wd;
    end
    slot(1'b1, 1'b0, 1'b0, rq);   // line released after the frame
  endtask

  task automatic core_all(input string rq);
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 32; a++) begin
        @(negedge clk);
        core_ch = 2'(c);
        core_addr = 5'(a);
        #1;
        chk(rq, 32'(core_rdata), 32'(impl(a) ? model[c][a] : 16'h0000), "core_rdata");
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 32; a++) model[c][a] = 16'h0000;
    for (int c = 0; c < 4; c++) begin
      model[c][0] = 16'h3100;
      model[c][1] = 16'h7849;
      model[c][2] = 16'h0016;
      model[c][3] = 16'hF840 + 16'(c);
    end

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", 32'(mdio_oe), 32'd0, "mdio_oe after reset");
    core_all("R1");

    // R5: plain read, channel 1 register 2
    pre(32, "R5");
    frame(1, 2'b10, {STRAP, 2'd1}, 5'd2, 16'h0, "R5");
    pre(32, "R5");
    frame(1, 2'b10, {STRAP, 2'd3}, 5'd3, 16'h0, "R5");

    // R6: writes then read back
    pre(32, "R6");
    frame(1, 2'b01, {STRAP, 2'd2}, 5'd0, 16'hA5C3, "R6");
    pre(32, "R6");
    frame(1, 2'b10, {STRAP, 2'd2}, 5'd0, 16'h0, "R6");
    pre(32, "R6");
    frame(1, 2'b01, {STRAP, 2'd3}, 5'd20, 16'h1234, "R6");
    pre(32, "R6");
    frame(1, 2'b10, {STRAP, 2'd3}, 5'd20, 16'h0, "R6");
    core_all("R11");

    // R8: unimplemented address
    pre(32, "R8");
    frame(1, 2'b01, {STRAP, 2'd0}, 5'd7, 16'hFFFF, "R8");
    pre(32, "R8");
    frame(1, 2'b10, {STRAP, 2'd0}, 5'd7, 16'h0, "R8");
    pre(32, "R8");
    frame(1, 2'b10, {STRAP, 2'd1}, 5'd31, 16'h0, "R8");
    core_all("R8");

    // R4: device address mismatch
    pre(32, "R4");
    frame(1, 2'b10, {3'b100, 2'd1}, 5'd0, 16'h0, "R4");
    pre(32, "R4");
    frame(1, 2'b01, {3'b001, 2'd1}, 5'd1, 16'h0000, "R4");
    core_all("R4");

    // R7: undefined opcodes
    pre(32, "R7");
    frame(1, 2'b00, {STRAP, 2'd0}, 5'd0, 16'h0000, "R7");
    pre(32, "R7");
    frame(1, 2'b11, {STRAP, 2'd0}, 5'd1, 16'h0000, "R7");
    core_all("R7");

    // R2: 31 ones is too short, exactly 32 is enough
    slot(1'b0, 1'b0, 1'b0, "R2");
    pre(31, "R2");
    frame(0, 2'b01, {STRAP, 2'd1}, 5'd4, 16'hBEEF, "R2");
    slot(1'b0, 1'b0, 1'b0, "R2");
    pre(32, "R2");
    frame(1, 2'b10, {STRAP, 2'd1}, 5'd4, 16'h0, "R2");
    core_all("R2");

    // R3: bad start aborts, recovery after new preamble
    pre(32, "R3");
    slot(1'b0, 1'b0, 1'b0, "R3");
    slot(1'b0, 1'b0, 1'b0, "R3");
    frame(0, 2'b10, {STRAP, 2'd2}, 5'd0, 16'h0, "R3");
    pre(32, "R3");
    frame(1, 2'b10, {STRAP, 2'd2}, 5'd0, 16'h0, "R3");

    // R9: bulk read of all registers
    pre(32, "R9");
    frame(1, 2'b01, {STRAP, 2'd1}, 5'd17, 16'h0F0F, "R9");
    bulk_en = 1'b1;
    pre(32, "R9");
    frame(1, 2'b10, {STRAP, 2'd2}, 5'd31, 16'h0, "R9");

    // R10: bulk write ignored
    pre(32, "R10");
    frame(1, 2'b01, {STRAP, 2'd0}, 5'd31, 16'h5555, "R10");
    core_all("R10");
    pre(32, "R10");
    frame(1, 2'b10, {STRAP, 2'd0}, 5'd31, 16'h0, "R10");
    bulk_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule